// File: doc/BRIEF.md
# MDIO Management Master with Register Front End

This block drives a two-wire station-management bus toward Ethernet PHYs. Software sees four 32-bit registers on a simple synchronous bus: a status/configuration word, a control word carrying the PHY port and device (or register) numbers, an extended-address word and a data word. Writing the right register starts a frame. The block then generates the management clock from the system clock, shifts out the preamble, start, opcode, address and turnaround fields, and either drives 16 data bits or releases the line and samples 16 bits from the PHY.

A mode bit chooses between the short-frame format, where the control word's device field is the PHY register number, and the extended format with separate address frames. While a frame runs, busy flags are visible in both the status and data words, and every register write is dropped. A read whose addressed device never pulls the second turnaround bit low sets an error flag and returns all ones.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Register offsets: 0 = STATUS (bit0 busy, read-only; bit1 read error, read-only; bit2 extended-format mode; bit3 early-drive flag; bits 25:16 clock divider), 1 = CONTROL (bits 4:0 device/register number, bits 9:5 port number, bit15 read request, which reads back 0), 2 = ADDR (bits 15:0), 3 = DATA (bits 15:0 data, bit31 busy). After reset the divider reads 258, every other field reads 0, `mdc` is 1 and `mdio_oe` is 0.
- R2: While a frame runs, `mdc` has a period of 2*(E+1) system clocks, where E is the divider, or 2 if the divider is below 2.
- R3: Between frames `mdc` stays high and `mdio_oe` stays low. The busy bits read 1 from the accepted launching write until the frame ends.
- R4: Every frame is 64 `mdc` cycles, sent MSB first: 32 ones, 2-bit start, 2-bit opcode, 5-bit port, 5-bit device, 2-bit turnaround (10 when driven), 16 data bits. In short-frame mode (bit2 = 0) the start code is 01, read uses opcode 10 and write uses opcode 01.
- R5: In extended mode (bit2 = 1) the start code is 00, and the opcodes are 00 for address, 01 for write and 11 for read.
- R6: A write to DATA stores the value and launches a write frame that carries it, with `mdio_oe` high for all 64 bits.
- R7: In extended mode a write to ADDR launches an address frame that carries the ADDR value, driven for all 64 bits. In short-frame mode the value is only stored and the bus stays idle.
- R8: A CONTROL write with bit15 set launches a read frame. With bit15 clear it only stores the port and device fields.
- R9: In a read frame `mdio_oe` is low from the first turnaround bit through the last data bit. Input is sampled on rising `mdc`, and the 16 data bits land in DATA[15:0].
- R10: If the second turnaround bit of a read is sampled high, the error bit is set and DATA[15:0] becomes 0xFFFF. The next accepted launching write clears the error bit.
- R11: Writes to any register while busy have no effect and launch nothing.
- R12: With the early-drive flag set, `mdio_o` changes in the same clock as the falling `mdc` edge. With it clear, the change comes floor(E/2)+1 clocks after that falling edge, still inside the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| mdio_i | input | 1 | Management data line input |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data line output value |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |

## Verification
The bench goes after the second turnaround bit with a PHY that is absent. A design that sampled the wrong cell or skipped the error path would return stale bits instead of 0xFFFF. Register writes are fired into a running frame, so a design that let them through would change the divider mid-frame, send a second frame or corrupt the data word. An ADDR write in short-frame mode and a CONTROL write without the read bit must leave `mdc` still; a loose decoder would emit a spurious frame. A divider below the floor and the typical 258 are both measured edge to edge, and in each edge-drive mode the clock offset of every data change is counted, so a design that changed data on the rising edge or off-centre would be caught.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int DATA_W     = 16;
  localparam int PRT_W      = 5;
  localparam int CNT_W      = 16;
  localparam int DIV_FLOOR  = 2;
  localparam int TA1_POS    = 46;
  localparam int TA2_POS    = 47;
  localparam int DAT_POS    = 48;
  localparam int RD_REQ_BIT = 15;
  localparam int DIV_LSB    = 16;
  localparam int BUSY_BIT   = 31;

  typedef enum logic [1:0] {
    RG_STATUS = 2'd0,
    RG_CTRL   = 2'd1,
    RG_ADDR   = 2'd2,
    RG_DATA   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } op_kind_e;

  // divider limit actually used by the clock generator
  function automatic logic [CNT_W-1:0] clamp_div(input logic [CNT_W-1:0] d);
    return (d < CNT_W'(DIV_FLOOR)) ? CNT_W'(DIV_FLOOR) : d;
  endfunction

  // full 64-bit serial image of one frame, MSB sent first
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic             ext,
    input op_kind_e         kind,
    input logic [PRT_W-1:0] port,
    input logic [PRT_W-1:0] dev,
    input logic [DATA_W-1:0] val);
    logic [1:0] st;
    logic [1:0] op;
    st = ext ? 2'b00 : 2'b01;
    case (kind)
      OP_ADDR:  op = 2'b00;
      OP_WRITE: op = 2'b01;
      default:  op = ext ? 2'b11 : 2'b10;
    endcase
    return {{(FRAME_BITS-32){1'b1}}, st, op, port, dev, 2'b10, val};
  endfunction

  // true when the master must not drive the bit at index i
  function automatic logic line_released(input logic is_rd, input logic [IDX_W-1:0] i);
    return is_rd && (i >= IDX_W'(TA1_POS));
  endfunction
endpackage

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W     = 10,
  parameter int DIV_RESET = 258
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            reg_addr,
  input  logic                  reg_we,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  run_i,
  input  logic                  rd_done_i,
  input  logic [DATA_W-1:0]     rd_val_i,
  input  logic                  rd_err_i,
  output logic                  early_o,
  output logic [DIV_W-1:0]      div_o,
  output logic                  launch_o,
  output logic                  is_read_o,
  output logic [FRAME_BITS-1:0] frame_o
);
  logic              ext_q, early_q, rerr_q, launch_q;
  logic [DIV_W-1:0]  div_q;
  logic [PRT_W-1:0]  port_q, dev_q;
  logic [DATA_W-1:0] addr_q, data_q;
  op_kind_e          kind_q;
  reg_sel_e          sel;
  logic              busy, accept;
  logic              unused_wdata;

  assign sel          = reg_sel_e'(reg_addr);
  assign busy         = run_i | launch_q;
  assign accept       = reg_we & ~busy;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q    <= 1'b0;
      early_q  <= 1'b0;
      div_q    <= DIV_W'(DIV_RESET);
      port_q   <= '0;
      dev_q    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      rerr_q   <= 1'b0;
      launch_q <= 1'b0;
      kind_q   <= OP_WRITE;
    end else begin
      launch_q <= 1'b0;
      if (accept) begin
        case (sel)
          RG_STATUS: begin
            ext_q   <= reg_wdata[2];
            early_q <= reg_wdata[3];
            div_q   <= reg_wdata[DIV_LSB +: DIV_W];
          end
          RG_CTRL: begin
            dev_q  <= reg_wdata[PRT_W-1:0];
            port_q <= reg_wdata[2*PRT_W-1:PRT_W];
            if (reg_wdata[RD_REQ_BIT]) begin
              launch_q <= 1'b1;
              kind_q   <= OP_READ;
              rerr_q   <= 1'b0;
            end
          end
          RG_ADDR: begin
            addr_q <= reg_wdata[DATA_W-1:0];
            if (ext_q) begin
              launch_q <= 1'b1;
              kind_q   <= OP_ADDR;
              rerr_q   <= 1'b0;
            end
          end
          default: begin
            data_q   <= reg_wdata[DATA_W-1:0];
            launch_q <= 1'b1;
            kind_q   <= OP_WRITE;
            rerr_q   <= 1'b0;
          end
        endcase
      end
      if (rd_done_i) begin
        data_q <= rd_val_i;
        rerr_q <= rd_err_i;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      RG_STATUS: begin
        reg_rdata[0] = busy;
        reg_rdata[1] = rerr_q;
        reg_rdata[2] = ext_q;
        reg_rdata[3] = early_q;
        reg_rdata[DIV_LSB +: DIV_W] = div_q;
      end
      RG_CTRL: begin
        reg_rdata[PRT_W-1:0]       = dev_q;
        reg_rdata[2*PRT_W-1:PRT_W] = port_q;
      end
      RG_ADDR: reg_rdata[DATA_W-1:0] = addr_q;
      default: begin
        reg_rdata[DATA_W-1:0] = data_q;
        reg_rdata[BUSY_BIT]   = busy;
      end
    endcase
  end

  assign early_o   = early_q;
  assign div_o     = div_q;
  assign launch_o  = launch_q;
  assign is_read_o = (kind_q == OP_READ);
  assign frame_o   = build_frame(ext_q, kind_q, port_q, dev_q,
                                 (kind_q == OP_ADDR) ? addr_q : data_q);

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && busy && !rd_done_i) |=> ($stable(div_q) && $stable(data_q) && $stable(addr_q) && !launch_q)); // R11
  AST_SHORT_ADDR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sel == RG_ADDR && !ext_q) |=> !launch_q); // R7
  AST_ERR_FORCES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rerr_q |-> (data_q == '1)); // R10
endmodule

// File: rtl/mdio_mdc_timer.sv
module mdio_mdc_timer
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 10
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             last_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             ev_mid_o,
  output logic             ev_rise_o,
  output logic             ev_end_o
);
  logic [CNT_W-1:0] cnt_q, lim, mid;
  logic             mdc_q, wrap;

  assign lim  = clamp_div(CNT_W'(div_i));
  assign mid  = lim >> 1;
  assign wrap = (cnt_q == lim);

  assign ev_rise_o = run_i & ~mdc_q & wrap;
  assign ev_mid_o  = run_i & ~mdc_q & (cnt_q == mid);
  assign ev_end_o  = run_i &  mdc_q & wrap;
  assign mdc_o     = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b1;
    end else if (start_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (run_i) begin
      if (wrap) begin
        cnt_q <= '0;
        if (!mdc_q)       mdc_q <= 1'b1;
        else if (!last_i) mdc_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= lim)); // R2
  AST_MDC_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> mdc_q); // R3
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  is_read_i,
  input  logic                  early_i,
  input  logic                  ev_mid_i,
  input  logic                  ev_rise_i,
  input  logic                  ev_end_i,
  input  logic                  mdio_i,
  output logic                  run_o,
  output logic                  last_o,
  output logic                  mdio_o,
  output logic                  mdio_oe_o,
  output logic                  rd_done_o,
  output logic [DATA_W-1:0]     rd_val_o,
  output logic                  rd_err_o
);
  logic [IDX_W-1:0]      idx_q, drv_idx;
  logic [FRAME_BITS-1:0] sh_q;
  logic [DATA_W-1:0]     cap_q;
  logic                  run_q, o_q, oe_q, err_q;
  logic                  is_last, drv_mid, drv_next;

  assign is_last  = (idx_q == IDX_W'(FRAME_BITS-1));
  assign drv_mid  = ev_mid_i & ~early_i;
  assign drv_next = ev_end_i & ~is_last & early_i;
  assign drv_idx  = drv_mid ? idx_q : idx_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      idx_q <= '0;
      sh_q  <= '0;
      cap_q <= '0;
      o_q   <= 1'b1;
      oe_q  <= 1'b0;
      err_q <= 1'b0;
    end else if (start_i) begin
      run_q <= 1'b1;
      idx_q <= '0;
      err_q <= 1'b0;
      if (early_i) begin
        o_q  <= frame_i[FRAME_BITS-1];
        oe_q <= 1'b1;
        sh_q <= frame_i << 1;
      end else begin
        sh_q <= frame_i;
      end
    end else if (run_q) begin
      if (drv_mid || drv_next) begin
        o_q  <= sh_q[FRAME_BITS-1];
        oe_q <= ~line_released(is_read_i, drv_idx);
        sh_q <= sh_q << 1;
      end
      if (ev_rise_i && is_read_i) begin
        if (idx_q == IDX_W'(TA2_POS))
          err_q <= mdio_i;
        else if (idx_q >= IDX_W'(DAT_POS))
          cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      end
      if (ev_end_i) begin
        if (is_last) begin
          run_q <= 1'b0;
          oe_q  <= 1'b0;
          o_q   <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign run_o     = run_q;
  assign last_o    = is_last;
  assign mdio_o    = o_q;
  assign mdio_oe_o = oe_q;
  assign rd_done_o = run_q & ev_end_i & is_last & is_read_i;
  assign rd_val_o  = err_q ? '1 : cap_q;
  assign rd_err_o  = err_q;

  AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !oe_q); // R3
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rise_i && is_read_i && idx_q >= IDX_W'(TA1_POS)) |-> !oe_q); // R9
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !run_q); // R11
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W     = 10,
  parameter int DIV_RESET = 258
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic                  early, launch, is_read, run, last;
  logic                  ev_mid, ev_rise, ev_end;
  logic                  rd_done, rd_err;
  logic [DIV_W-1:0]      div;
  logic [DATA_W-1:0]     rd_val;
  logic [FRAME_BITS-1:0] frame;

  mdio_csr #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .run_i(run), .rd_done_i(rd_done), .rd_val_i(rd_val), .rd_err_i(rd_err),
    .early_o(early), .div_o(div), .launch_o(launch), .is_read_o(is_read), .frame_o(frame)
  );

  mdio_mdc_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start_i(launch), .run_i(run), .last_i(last), .div_i(div),
    .mdc_o(mdc), .ev_mid_o(ev_mid), .ev_rise_o(ev_rise), .ev_end_o(ev_end)
  );

  mdio_frame_engine u_engine (
    .clk(clk), .rst_n(rst_n),
    .start_i(launch), .frame_i(frame), .is_read_i(is_read), .early_i(early),
    .ev_mid_i(ev_mid), .ev_rise_i(ev_rise), .ev_end_i(ev_end), .mdio_i(mdio_i),
    .run_o(run), .last_o(last), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe),
    .rd_done_o(rd_done), .rd_val_o(rd_val), .rd_err_o(rd_err)
  );

  AST_OE_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> !mdc || run); // R3
endmodule

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
  localparam int K_ADDR = 0;
  localparam int K_WR   = 1;
  localparam int K_RD   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        mdio_i = 1'b1;
  wire  [31:0] reg_rdata;
  wire         mdc, mdio_o, mdio_oe;

  always #10 clk = ~clk;

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // PHY side: record every bit at rising mdc, answer reads after falling mdc
  int          bitcnt = 0;
  logic [63:0] obs_o = '0, obs_oe = '0;
  logic        ph_present = 1'b1;
  logic [15:0] ph_val = '0;

  function automatic logic phy_bit(input int k, input logic present, input logic [15:0] v);
    if (k == 47) return !present;
    if (k >= 48 && k < 64) return present ? v[63-k] : 1'b1;
    return 1'b1;
  endfunction

  always @(posedge mdc) begin
    if (bitcnt < 64) begin
      obs_o[63-bitcnt]  = mdio_o;
      obs_oe[63-bitcnt] = mdio_oe;
    end
    bitcnt++;
  end

  always @(negedge mdc) mdio_i = phy_bit(bitcnt, ph_present, ph_val);

  // edge timing monitor
  bit   mon_en = 0, seen_fall = 0;
  int   sf = 0, exp_per = 0, exp_off = 0, per_err = 0, off_err = 0;
  logic pm = 1'b1, po = 1'b1, poe = 1'b0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (pm && !mdc) begin
        if (seen_fall && sf + 1 != exp_per) per_err++;
        seen_fall = 1;
        sf = 0;
      end else sf++;
      if (mdio_oe && (!poe || mdio_o !== po) && sf != exp_off) off_err++;
    end
    pm = mdc; po = mdio_o; poe = mdio_oe;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do rd(2'd0, s); while (s[0]);
  endtask

  function automatic logic [63:0] exp_frame(input int kind, input logic ext,
      input logic [4:0] p, input logic [4:0] d, input logic [15:0] v);
    logic [63:0] f;
    f = '1;
    f[31:30] = ext ? 2'b00 : 2'b01;
    f[29:28] = (kind == K_ADDR) ? 2'b00 : (kind == K_WR) ? 2'b01 : (ext ? 2'b11 : 2'b10);
    f[27:23] = p;
    f[22:18] = d;
    f[17:16] = 2'b10;
    f[15:0]  = v;
    return f;
  endfunction

  function automatic int eff_div(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  task automatic run_frame(input int kind, input logic ext, input logic early, input int div,
      input logic [4:0] p, input logic [4:0] d, input logic [15:0] v,
      input logic present, input bit poke);
    logic [31:0] s, cfg;
    logic [63:0] ef, mask, eoe;
    string       ftag, otag;
    cfg = (32'(div) << 16) | (32'(early) << 3) | (32'(ext) << 2);
    wr(2'd0, cfg);
    wr(2'd1, 32'({p, d}));
    ph_present = present;
    ph_val     = v;
    bitcnt = 0; seen_fall = 0; per_err = 0; off_err = 0;
    exp_per = 2 * (eff_div(div) + 1);
    exp_off = early ? 0 : (eff_div(div) / 2 + 1);
    mon_en = 1;
    case (kind)
      K_WR:    wr(2'd3, 32'(v));
      K_RD:    wr(2'd1, 32'h8000 | 32'({p, d}));
      default: wr(2'd2, 32'(v));
    endcase
    rd(2'd0, s);
    check(s[0] == 1'b1, "R3 busy during frame", 64'(s[0]), 64'd1);
    if (poke) begin
      repeat (40) @(negedge clk);
      wr(2'd0, 32'h0009_0004 ^ cfg);
      wr(2'd3, 32'(~v));
      wr(2'd2, 32'h0000_5A5A);
      wr(2'd1, 32'h0000_83FF);
    end
    wait_idle();
    mon_en = 0;
    ef   = exp_frame(kind, ext, p, d, v);
    mask = (kind == K_RD) ? {46'h3FFF_FFFF_FFFF, 18'h0} : '1;
    eoe  = mask;
    ftag = ext ? "R5 frame bits" : "R4 frame bits";
    otag = (kind == K_RD) ? "R9 drive enable" : (kind == K_WR) ? "R6 drive enable" : "R7 drive enable";
    check(bitcnt == 64, "R4 mdc cycles per frame", 64'(bitcnt), 64'd64);
    check(((obs_o ^ ef) & mask) == 0, ftag, obs_o & mask, ef & mask);
    check(obs_oe == eoe, otag, obs_oe, eoe);
    check(per_err == 0, "R2 mdc period", 64'(per_err), 64'd0);
    check(off_err == 0, "R12 data change offset", 64'(off_err), 64'd0);
    if (kind == K_RD) begin
      rd(2'd3, s);
      check(s[15:0] == (present ? v : 16'hFFFF), present ? "R9 read data" : "R10 read all ones",
            64'(s[15:0]), 64'(present ? v : 16'hFFFF));
      rd(2'd0, s);
      check(s[1] == !present, "R10 read error flag", 64'(s[1]), 64'(!present));
    end
    if (poke) begin
      rd(2'd0, s);
      check((s & 32'hFFFF_FFFC) == cfg, "R11 status kept", 64'(s), 64'(cfg));
      rd(2'd3, s);
      check(s[15:0] == v, "R11 data kept", 64'(s[15:0]), 64'(v));
      rd(2'd1, s);
      check(s == 32'({p, d}), "R11 control kept", 64'(s), 64'({p, d}));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    void'($urandom(32'h00C0FFEE));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, s); check(s == 32'd258 << 16, "R1 status reset", 64'(s), 64'(32'd258 << 16));
    rd(2'd1, s); check(s == 0, "R1 control reset", 64'(s), 64'd0);
    rd(2'd2, s); check(s == 0, "R1 addr reset", 64'(s), 64'd0);
    rd(2'd3, s); check(s == 0, "R1 data reset", 64'(s), 64'd0);
    check(mdc == 1'b1 && mdio_oe == 1'b0, "R1 pins at reset", 64'({mdc, mdio_oe}), 64'b10);

    // R8 control write without read request: stored only
    wr(2'd0, 32'h0004_0000);
    bitcnt = 0;
    wr(2'd1, 32'h0000_0000 | 32'({5'd9, 5'd22}));
    repeat (20) @(negedge clk);
    rd(2'd1, s); check(s == 32'({5'd9, 5'd22}), "R8 control stored", 64'(s), 64'({5'd9, 5'd22}));
    rd(2'd0, s); check(s[0] == 1'b0 && bitcnt == 0, "R8 no frame", 64'({s[0], 32'(bitcnt)}), 64'd0);

    // R7 short-frame ADDR write: stored only
    wr(2'd2, 32'h0000_BEEF);
    repeat (20) @(negedge clk);
    rd(2'd2, s); check(s == 32'hBEEF, "R7 addr stored", 64'(s), 64'hBEEF);
    check(bitcnt == 0 && mdc == 1'b1, "R7 short mode addr idle", 64'(bitcnt), 64'd0);

    // directed frames
    run_frame(K_WR,   1'b0, 1'b0, 3, 5'd1,  5'd2,  16'hA5C3, 1'b1, 1'b0);
    run_frame(K_RD,   1'b0, 1'b1, 2, 5'd31, 5'd0,  16'h1357, 1'b1, 1'b0);
    run_frame(K_ADDR, 1'b1, 1'b0, 4, 5'd7,  5'd30, 16'hFFFE, 1'b1, 1'b0);
    run_frame(K_WR,   1'b1, 1'b1, 5, 5'd16, 5'd1,  16'h0001, 1'b1, 1'b0);
    run_frame(K_RD,   1'b1, 1'b0, 6, 5'd3,  5'd3,  16'h8000, 1'b1, 1'b0);
    // R10 absent device, then cleared by the next launch
    run_frame(K_RD,   1'b1, 1'b1, 2, 5'd12, 5'd5,  16'h0F0F, 1'b0, 1'b0);
    run_frame(K_WR,   1'b0, 1'b0, 2, 5'd12, 5'd5,  16'h2222, 1'b1, 1'b0);
    rd(2'd0, s); check(s[1] == 1'b0, "R10 error cleared by launch", 64'(s[1]), 64'd0);
    // R11 writes while busy
    run_frame(K_WR,   1'b1, 1'b0, 5, 5'd21, 5'd10, 16'h6C6C, 1'b1, 1'b1);
    // R2 divider below floor and the typical divider
    run_frame(K_WR,   1'b0, 1'b0, 0, 5'd2,  5'd4,  16'h4242, 1'b1, 1'b0);
    run_frame(K_WR,   1'b0, 1'b1, 258, 5'd0, 5'd1, 16'h9ABC, 1'b1, 1'b0);

    // constrained random
    for (int i = 0; i < 16; i++) begin
      int          kind;
      logic        ext;
      kind = int'($urandom_range(2, 0));
      ext  = 1'($urandom_range(1, 0));
      if (kind == K_ADDR && !ext) kind = K_WR;
      run_frame(kind, ext, 1'($urandom_range(1, 0)), int'($urandom_range(9, 2)),
                5'($urandom), 5'($urandom), 16'($urandom),
                ($urandom_range(3, 0) != 0), 1'b0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule